// File: doc/BRIEF.md
# Programmable UART bit-rate generator

This block turns one fast reference clock into a single square wave at sixteen times a chosen baud rate, for use as the sampling clock of a serial receiver or transmitter. A 4-bit rate code picks one of thirteen internally divided rates, or routes an external input straight to the output. With a 2.4576 MHz reference the internal rates span 50 to 9600 baud. A slower reference scales every rate down in the same proportion.

The reference comes from one of two sources: a crystal-side input or an external clock input. Both are sampled by the system clock `clk`, and each rising edge of the chosen source counts as one active edge. A binary counter serves as both the 3-bit scan counter, whose bits are exported, and the divide-by-2 stage. Its higher bits form the binary rate chain. Four modulo counters and a fractional accumulator produce the rates that are not powers of two. The selected rate is captured in an output register on each active edge, and so is the external input. The exported scan bits let the output be time-shared across channels, and looping scan bit 2 back to the external input gives twice the fastest internal rate.

Top module: `baud_rate_gen`

## Requirements
- R1: With `use_xtal` = 1 only rising edges of `xtal_in` are active edges. With `use_xtal` = 0 only rising edges of `ext_clk` are. `co` is the selected source delayed by one `clk`.
- R2: While `use_xtal` and `ext_clk` are both 1, every counter and `bit_clk` are held at 0.
- R3: After `use_xtal` falls, the first high level of `ext_clk` clears every counter and counts no edge. The next rising edge of `ext_clk` counts, so `scan_q` reads 1 after it.
- R4: Each active edge advances `scan_q` by one, modulo 8.
- R5: The binary rates are square waves with 50% duty, measured in active edges per period: code 8 → 16, code 9 → 32, codes 7 and 12 → 64, code 11 → 128, code 6 → 256, code 13 → 512, code 14 → 1024, code 3 → 2048.
- R6: The divided rates are square waves with 50% duty: code 5 → 768, code 2 → 3072, code 4 → 1152, code 15 → 1408 active edges per period.
- R7: Code 10 adds 3 per active edge modulo 128 and toggles on each wrap. Its periods are 85 or 86 active edges and average 256/3.
- R8: With code 0 or 1, `bit_clk` takes the value `mux_in` had at the most recent active edge.
- R9: `bit_clk` changes only at an active edge or a reset. Input changes between active edges have no effect on it. A reset clears it to 0.
- R10: With `mux_in` tied to `scan_q[2]` and code 1, `bit_clk` has a period of 8 active edges at 50% duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples both sources |
| rst_n | input | 1 | Synchronous active-low reset |
| xtal_in | input | 1 | Crystal-side reference input |
| ext_clk | input | 1 | External reference input; also drives the initialization reset |
| use_xtal | input | 1 | 1 selects `xtal_in`, 0 selects `ext_clk` |
| rate_sel | input | 4 | Rate code, bit 3 most significant |
| mux_in | input | 1 | External input passed through on codes 0 and 1 |
| co | output | 1 | Registered copy of the selected source |
| scan_q | output | 3 | Scan counter bits |
| bit_clk | output | 1 | Registered rate output |

## Verification
The bench builds the block with its default parameters: an 11-bit chain, a 128-step accumulator with step 3, and half-periods of 384, 1536, 576 and 704. The bench toggles the reference on every `clk` cycle, which makes each active edge two `clk` cycles long. At that speed even the longest period, 3072 edges, can be measured after a resync in every one of the fourteen internal codes. These values also make the 85/86 spread of the fractional divider visible as an exact count.

// File: rtl/baud_rate_gen.sv
module baud_rate_gen #(
  parameter int CHAIN_W   = 11,
  parameter int FRAC_MOD  = 128,
  parameter int FRAC_STEP = 3,
  parameter int HALF_200  = 384,
  parameter int HALF_50   = 1536,
  parameter int HALF_134  = 576,
  parameter int HALF_110  = 704
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xtal_in,
  input  logic       ext_clk,
  input  logic       use_xtal,
  input  logic [3:0] rate_sel,
  input  logic       mux_in,
  output logic       co,
  output logic [2:0] scan_q,
  output logic       bit_clk
);
  localparam int NDIV   = 4;
  localparam int DIV_W  = $clog2(HALF_200 + HALF_50 + HALF_134 + HALF_110);
  localparam int FRAC_W = $clog2(FRAC_MOD);
  localparam int B0     = 3;
  localparam int HALF [NDIV] = '{HALF_200, HALF_50, HALF_134, HALF_110};

  logic src_q, ext_q, armed, z, frac_q, sel_bit;
  logic [CHAIN_W-1:0] cnt;
  logic [FRAC_W-1:0]  acc;
  logic [FRAC_W:0]    acc_nxt;
  logic [NDIV-1:0]    dv;

  wire src  = use_xtal ? xtal_in : ext_clk;
  wire mrst = ext_clk & (use_xtal | armed);
  wire tick = src & ~src_q & ~mrst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      ext_q <= 1'b0;
      armed <= 1'b1;
    end else begin
      src_q <= src;
      ext_q <= ext_clk;
      if (use_xtal) armed <= 1'b1;
      else if (ext_q && !ext_clk) armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mrst) cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  for (genvar g = 0; g < NDIV; g++) begin : g_div
    logic [DIV_W-1:0] dc;
    logic             dq;
    always_ff @(posedge clk) begin
      if (!rst_n || mrst) begin
        dc <= '0;
        dq <= 1'b0;
      end else if (tick) begin
        if (dc == DIV_W'(HALF[g] - 1)) begin
          dc <= '0;
          dq <= ~dq;
        end else begin
          dc <= dc + 1'b1;
        end
      end
    end
    assign dv[g] = dq;
  end

  assign acc_nxt = {1'b0, acc} + (FRAC_W+1)'(FRAC_STEP);

  always_ff @(posedge clk) begin
    if (!rst_n || mrst) begin
      acc    <= '0;
      frac_q <= 1'b0;
    end else if (tick) begin
      if (acc_nxt >= (FRAC_W+1)'(FRAC_MOD)) begin
        acc    <= FRAC_W'(acc_nxt - (FRAC_W+1)'(FRAC_MOD));
        frac_q <= ~frac_q;
      end else begin
        acc <= acc_nxt[FRAC_W-1:0];
      end
    end
  end

  always_comb begin
    case (rate_sel)
      4'd0, 4'd1: sel_bit = mux_in;
      4'd2:       sel_bit = dv[1];
      4'd3:       sel_bit = cnt[B0+7];
      4'd4:       sel_bit = dv[2];
      4'd5:       sel_bit = dv[0];
      4'd6:       sel_bit = cnt[B0+4];
      4'd7:       sel_bit = cnt[B0+2];
      4'd8:       sel_bit = cnt[B0];
      4'd9:       sel_bit = cnt[B0+1];
      4'd10:      sel_bit = frac_q;
      4'd11:      sel_bit = cnt[B0+3];
      4'd12:      sel_bit = cnt[B0+2];
      4'd13:      sel_bit = cnt[B0+5];
      4'd14:      sel_bit = cnt[B0+6];
      default:    sel_bit = dv[3];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mrst) z <= 1'b0;
    else if (tick) z <= sel_bit;
  end

  assign co      = src_q;
  assign scan_q  = cnt[2:0];
  assign bit_clk = z;

  p_hold_in_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (use_xtal && ext_clk) |=> (scan_q == 3'd0 && bit_clk == 1'b0));

  p_init_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_xtal && ext_clk && armed) |=> (scan_q == 3'd0));

  p_scan_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (scan_q == $past(scan_q) + 3'd1));

  p_im_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rate_sel[3:1] == 3'd0) |=> (bit_clk == $past(mux_in)));

  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !mrst) |=> $stable(bit_clk));
endmodule

// File: tb/sim_baud_rate_gen.sv
`timescale 1ns/1ps
module sim_baud_rate_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic xtal_in = 1'b0, ext_clk = 1'b0, use_xtal = 1'b1;
  logic [3:0] rate_sel = 4'd8;
  logic im_drv = 1'b0, im_loop = 1'b0;
  logic run_x = 1'b0, run_e = 1'b0;
  logic co, bit_clk;
  logic [2:0] scan_q;
  wire mux_w = im_loop ? scan_q[2] : im_drv;
  int cyc = 0, nchk = 0, nfail = 0;

  baud_rate_gen u0 (.clk(clk), .rst_n(rst_n), .xtal_in(xtal_in), .ext_clk(ext_clk),
    .use_xtal(use_xtal), .rate_sel(rate_sel), .mux_in(mux_w), .co(co),
    .scan_q(scan_q), .bit_clk(bit_clk));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (run_x) xtal_in = ~xtal_in;
    if (run_e) ext_clk = ~ext_clk;
  endtask

  task automatic wait_lvl(input logic lvl, output int t);
    step();
    while (bit_clk !== lvl) step();
    t = cyc;
  endtask

  function automatic int exp_per(input int c);
    case (c)
      8: return 16;     9: return 32;    7, 12: return 64;  11: return 128;
      6: return 256;   13: return 512;  14: return 1024;    3: return 2048;
      5: return 768;    2: return 3072;  4: return 1152;   15: return 1408;
      default: return 0;
    endcase
  endfunction

  task automatic measure(input int c, output int per, output int hi);
    int t0, t1, t2;
    rate_sel = 4'(c);
    wait_lvl(1'b0, t0); wait_lvl(1'b1, t0);
    wait_lvl(1'b0, t0); wait_lvl(1'b1, t0);
    wait_lvl(1'b0, t1); wait_lvl(1'b1, t2);
    per = (t2 - t0) / 2;
    hi  = (t1 - t0) / 2;
  endtask

  task automatic check_rate(input int c);
    int per, hi, e;
    measure(c, per, hi);
    e = exp_per(c);
    if (c == 10) begin
      chk(per == 85 || per == 86, "R7 fractional period", per, 85);
    end else if (c == 2 || c == 4 || c == 5 || c == 15) begin
      chk(per == e, "R6 divided period", per, e);
      chk(hi == e / 2, "R6 divided duty", hi, e / 2);
    end else begin
      chk(per == e, "R5 binary period", per, e);
      chk(hi == e / 2, "R5 binary duty", hi, e / 2);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 200000);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int s, per, hi, off, k, bad, v;
    int ks[6] = '{1, 3, 5, 9, 11, 13};
    s = $urandom(32'd2718);
    repeat (4) step();
    rst_n = 1'b1;
    step();
    chk(scan_q == 3'd0 && bit_clk == 1'b0 && co == 1'b0, "R9 reset state", {scan_q, bit_clk}, 0);

    // R2: continuous reset while crystal selected and ext_clk high
    run_x = 1'b1; ext_clk = 1'b1; bad = 0;
    repeat (20) begin step(); if (scan_q != 0 || bit_clk != 0) bad++; end
    chk(bad == 0, "R2 held in reset", bad, 0);
    ext_clk = 1'b0;
    step(); step(); s = scan_q;
    step(); step();
    chk(scan_q == 3'((s + 1) % 8), "R4 one step per edge", scan_q, (s + 1) % 8);
    repeat (6) step();
    s = scan_q;
    step(); step();
    chk(scan_q == 3'((s + 1) % 8), "R4 step after wrap region", scan_q, (s + 1) % 8);

    // R1/R3: switch to external clock
    run_x = 1'b0; xtal_in = 1'b0;
    step(); step(); s = scan_q;
    use_xtal = 1'b0;
    step();
    xtal_in = 1'b1; step(); xtal_in = 1'b0; step(); xtal_in = 1'b1; step(); xtal_in = 1'b0; step();
    chk(scan_q == 3'(s), "R1 crystal ignored in external mode", scan_q, s);
    ext_clk = 1'b1; step();
    chk(scan_q == 3'd0, "R3 first high clears", scan_q, 0);
    step(); step();
    chk(scan_q == 3'd0, "R3 no count during first high", scan_q, 0);
    ext_clk = 1'b0; step(); step();
    ext_clk = 1'b1; step();
    chk(scan_q == 3'd1, "R3 next edge counts", scan_q, 1);
    chk(co == 1'b1, "R1 co follows external source", co, 1);
    ext_clk = 1'b0; step(); ext_clk = 1'b1; step();
    chk(scan_q == 3'd2, "R4 external edge count", scan_q, 2);
    run_e = 1'b1;
    measure(8, per, hi);
    chk(per == 16, "R1 external source rate", per, 16);

    // back to crystal
    run_e = 1'b0; ext_clk = 1'b0; use_xtal = 1'b1;
    step(); step();
    run_x = 1'b1;

    // R5/R6/R7: all internal codes in a seeded random order
    off = $urandom % 14;
    k = ks[$urandom % 6];
    for (int i = 0; i < 14; i++) check_rate(2 + ((i * k + off) % 14));

    // R8/R9: external input pass-through, random data
    run_x = 1'b0; xtal_in = 1'b0;
    step(); step();
    for (int i = 0; i < 24; i++) begin
      rate_sel = 4'($urandom % 2);
      v = $urandom % 2;
      xtal_in = 1'b1; im_drv = 1'(v);
      step();
      chk(bit_clk == 1'(v), "R8 input captured on edge", bit_clk, v);
      xtal_in = 1'b0; im_drv = ~1'(v);
      rate_sel = 4'(2 + $urandom % 14);
      step();
      chk(bit_clk == 1'(v), "R9 no change between edges", bit_clk, v);
      rate_sel = 4'd0;
    end

    // R10: scan bit 2 looped into the external input
    im_loop = 1'b1; run_x = 1'b1;
    measure(1, per, hi);
    chk(per == 8, "R10 loopback period", per, 8);
    chk(hi == 4, "R10 loopback duty", hi, 4);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule